// File: doc/BRIEF.md
# Six-Sector Region and Reference Selector

This block sits in front of the carrier comparator of a three-level, four-leg inverter modulator. Each sample brings three signed phase references, for phases A, B and C measured to the neutral. From the signs of these three values the block finds which of the six 60-degree regions of the fundamental period is active. It then picks three modulating references for that region: two line voltages for the main legs and one phase voltage, sometimes negated, for the fourth leg.

Each chosen reference is compared with half the DC bus, E, which is supplied as an input. If the reference is at or above E, a position flag is raised and E is subtracted. Otherwise the flag stays low and the reference passes through unchanged. Downstream, the flag picks which switch pair of the leg is modulated, and the offset reference drives the duty comparison.

When all three phases share one sign class, the block keeps the region it last used, so that it does not toggle near zero crossings. The outputs are registered, and a result appears one cycle after its input strobe.

Top module: `sector_ref_select`

## Requirements
- R1: While reset is high and after reset until the first strobe: out_valid is 0, region is 1, all three references are 0 and all three flags are 0.
- R2: out_valid equals the in_valid of the previous clock cycle. A strobe sampled at one rising edge gives its result right after that edge.
- R3: A phase counts as positive when it is greater than zero. Zero counts as not positive. With the positive pattern written as {A,B,C}, 101 gives region 1, 100 gives region 2, 110 gives region 3, 010 gives region 4, 011 gives region 5 and 001 gives region 6.
- R4: On a strobe whose pattern is 000 (including all-zero inputs) or 111, the region keeps its previous value. The references are formed for that kept region from the new sample.
- R5: Write Vxy = Vx − Vy. The selected (P, N, X) references are: region 1 (VAB, VCB, −VB), region 2 (VAB, VAC, VA), region 3 (VBC, VAC, −VC), region 4 (VBC, VBA, VB), region 5 (VCA, VBA, −VA), region 6 (VCA, VCB, VC). These are computed exactly, with no wrap, for any 16-bit inputs.
- R6: When a selected reference is greater than or equal to half_bus, its flag is 1 and its output is the selected value minus half_bus. The output is exact over the full input range.
- R7: When a selected reference is less than half_bus, its flag is 0 and its output is the selected value unchanged.
- R8: In a cycle with in_valid low, region, references and flags keep their values.
- R9: The region output is always within 1 to 6.
- R10: A selected reference exactly equal to half_bus gives flag 1 and output 0. This holds even in a cycle where the region also changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe |
| va | input | 16 | Phase A reference, signed |
| vb | input | 16 | Phase B reference, signed |
| vc | input | 16 | Phase C reference, signed |
| half_bus | input | 16 | Half DC bus level E, signed |
| out_valid | output | 1 | Result strobe |
| region | output | 3 | Active region, 1 to 6 |
| ref_p | output | 18 | First main-leg reference after offset, signed |
| ref_n | output | 18 | Second main-leg reference after offset, signed |
| ref_x | output | 18 | Fourth-leg reference after offset, signed |
| flag_p | output | 1 | ref_p above-half-bus flag |
| flag_n | output | 1 | ref_n above-half-bus flag |
| flag_x | output | 1 | ref_x above-half-bus flag |

## Verification
A region change and a flag decision at the exact half-bus boundary can happen on the same strobe. The new region then chooses a reference that equals E, and the flag and offset must be applied to that newly chosen value. The bench provokes this with a region-2 sample followed directly by a region-1 sample whose VAB equals E, and a second such sample where the negated phase equals E. A behavioural model predicts region, flags and offset values and judges every cycle, alongside a three-phase sine sweep, held-region patterns, full-scale extremes and random strobes.

// File: rtl/sector_ref_pkg.sv
package sector_ref_pkg;

    typedef enum logic [2:0] {
        REG_I   = 3'd1,
        REG_II  = 3'd2,
        REG_III = 3'd3,
        REG_IV  = 3'd4,
        REG_V   = 3'd5,
        REG_VI  = 3'd6
    } region_e;

    localparam region_e REGION_RESET = REG_I;
    localparam int      NUM_REFS     = 3;
    localparam int      IDX_P        = 0;
    localparam int      IDX_N        = 1;
    localparam int      IDX_X        = 2;

    // pos = {A>0, B>0, C>0}; a uniform pattern keeps the previous region
    function automatic region_e next_region(input logic [2:0] pos, input region_e prev);
        region_e r;
        case (pos)
            3'b101:  r = REG_I;
            3'b100:  r = REG_II;
            3'b110:  r = REG_III;
            3'b010:  r = REG_IV;
            3'b011:  r = REG_V;
            3'b001:  r = REG_VI;
            default: r = prev;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sector_region_detect.sv
module sector_region_detect
    import sector_ref_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic signed [DATA_W-1:0] va,
    input  logic signed [DATA_W-1:0] vb,
    input  logic signed [DATA_W-1:0] vc,
    input  region_e                  prev_region,
    output region_e                  new_region,
    output logic                     uniform
);
    logic [2:0] pos;

    always_comb begin
        pos        = {va > 0, vb > 0, vc > 0};
        uniform    = (pos == 3'b000) || (pos == 3'b111);
        new_region = next_region(pos, prev_region);
    end
endmodule

// File: rtl/sector_ref_mux.sv
module sector_ref_mux
    import sector_ref_pkg::*;
#(
    parameter  int DATA_W = 16,
    localparam int LINE_W = DATA_W + 1
) (
    input  logic signed [DATA_W-1:0] va,
    input  logic signed [DATA_W-1:0] vb,
    input  logic signed [DATA_W-1:0] vc,
    input  region_e                  region,
    output logic signed [LINE_W-1:0] sel_p,
    output logic signed [LINE_W-1:0] sel_n,
    output logic signed [LINE_W-1:0] sel_x
);
    logic signed [LINE_W-1:0] ea, eb, ec;
    logic signed [LINE_W-1:0] vab, vbc, vca;

    always_comb begin
        ea  = $signed({va[DATA_W-1], va});
        eb  = $signed({vb[DATA_W-1], vb});
        ec  = $signed({vc[DATA_W-1], vc});
        vab = ea - eb;
        vbc = eb - ec;
        vca = ec - ea;
    end

    // main legs take line voltages, the fourth leg a phase voltage
    always_comb begin
        case (region)
            REG_I:   begin sel_p = vab; sel_n = -vbc; sel_x = -eb; end
            REG_II:  begin sel_p = vab; sel_n = -vca; sel_x = ea;  end
            REG_III: begin sel_p = vbc; sel_n = -vca; sel_x = -ec; end
            REG_IV:  begin sel_p = vbc; sel_n = -vab; sel_x = eb;  end
            REG_V:   begin sel_p = vca; sel_n = -vab; sel_x = -ea; end
            REG_VI:  begin sel_p = vca; sel_n = -vbc; sel_x = ec;  end
            default: begin sel_p = '0;  sel_n = '0;   sel_x = '0;  end
        endcase
    end
endmodule

// File: rtl/sector_level_split.sv
module sector_level_split #(
    parameter int DATA_W = 16,
    parameter int IN_W   = DATA_W + 1,
    parameter int OUT_W  = DATA_W + 2
) (
    input  logic signed [IN_W-1:0]   sel,
    input  logic signed [DATA_W-1:0] half_bus,
    output logic                     above,
    output logic signed [OUT_W-1:0]  level
);
    logic signed [OUT_W-1:0] xs, xe;

    always_comb begin
        xs    = $signed({{(OUT_W-IN_W){sel[IN_W-1]}}, sel});
        xe    = $signed({{(OUT_W-DATA_W){half_bus[DATA_W-1]}}, half_bus});
        above = (xs >= xe);
        level = above ? (xs - xe) : xs;
    end
endmodule

// File: rtl/sector_ref_select.sv
module sector_ref_select
    import sector_ref_pkg::*;
#(
    parameter  int DATA_W = 16,
    localparam int LINE_W = DATA_W + 1,
    localparam int REF_W  = DATA_W + 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] va,
    input  logic signed [DATA_W-1:0] vb,
    input  logic signed [DATA_W-1:0] vc,
    input  logic signed [DATA_W-1:0] half_bus,
    output logic                     out_valid,
    output logic [2:0]               region,
    output logic signed [REF_W-1:0]  ref_p,
    output logic signed [REF_W-1:0]  ref_n,
    output logic signed [REF_W-1:0]  ref_x,
    output logic                     flag_p,
    output logic                     flag_n,
    output logic                     flag_x
);
    region_e                  region_q, region_d;
    logic                     uniform;
    logic signed [LINE_W-1:0] sel   [NUM_REFS];
    logic signed [REF_W-1:0]  lvl_d [NUM_REFS];
    logic signed [REF_W-1:0]  lvl_q [NUM_REFS];
    logic [NUM_REFS-1:0]      flg_d, flg_q;
    logic                     valid_q;

    sector_region_detect #(.DATA_W(DATA_W)) u_detect (
        .va(va), .vb(vb), .vc(vc),
        .prev_region(region_q),
        .new_region(region_d),
        .uniform(uniform)
    );

    sector_ref_mux #(.DATA_W(DATA_W)) u_mux (
        .va(va), .vb(vb), .vc(vc),
        .region(region_d),
        .sel_p(sel[IDX_P]),
        .sel_n(sel[IDX_N]),
        .sel_x(sel[IDX_X])
    );

    for (genvar g = 0; g < NUM_REFS; g++) begin : g_split
        sector_level_split #(.DATA_W(DATA_W), .IN_W(LINE_W), .OUT_W(REF_W)) u_split (
            .sel(sel[g]),
            .half_bus(half_bus),
            .above(flg_d[g]),
            .level(lvl_d[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q  <= 1'b0;
            region_q <= REGION_RESET;
            flg_q    <= '0;
            for (int i = 0; i < NUM_REFS; i++) lvl_q[i] <= '0;
        end else begin
            valid_q <= in_valid;
            if (in_valid) begin
                region_q <= region_d;
                flg_q    <= flg_d;
                for (int i = 0; i < NUM_REFS; i++) lvl_q[i] <= lvl_d[i];
            end
        end
    end

    assign out_valid = valid_q;
    assign region    = region_q;
    assign ref_p     = lvl_q[IDX_P];
    assign ref_n     = lvl_q[IDX_N];
    assign ref_x     = lvl_q[IDX_X];
    assign flag_p    = flg_q[IDX_P];
    assign flag_n    = flg_q[IDX_N];
    assign flag_x    = flg_q[IDX_X];

    // R2
    a_r2_strobe_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r2_strobe_drops: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R8
    a_r8_quiet_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(region_q) && $stable(flg_q) && $stable(ref_p)
                      && $stable(ref_n) && $stable(ref_x));
    // R9
    a_r9_region_legal: assert property (@(posedge clk) disable iff (rst)
        (region >= 3'd1) && (region <= 3'd6));
    // R4
    a_r4_uniform_keeps: assert property (@(posedge clk) disable iff (rst)
        in_valid && uniform |=> region_q == $past(region_q));

    for (genvar g = 0; g < NUM_REFS; g++) begin : g_chk
        // R6
        a_r6_above_nonneg: assert property (@(posedge clk) disable iff (rst)
            out_valid && flg_q[g] |-> lvl_q[g] >= 0);
        // R7
        a_r7_below_under_e: assert property (@(posedge clk) disable iff (rst)
            out_valid && !flg_q[g] |-> lvl_q[g] < $signed($past(half_bus)));
    end
endmodule

// File: tb/sector_ref_select_bench.sv
`timescale 1ns/1ps
module sector_ref_select_bench;
    localparam int  DATA_W = 16;
    localparam int  REF_W  = DATA_W + 2;
    localparam time CLK_T  = 8ns;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic signed [DATA_W-1:0] va = '0, vb = '0, vc = '0, half_bus = '0;
    logic out_valid;
    logic [2:0] region;
    logic signed [REF_W-1:0] ref_p, ref_n, ref_x;
    logic flag_p, flag_n, flag_x;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int m_valid = 0;
    int m_region = 1;
    int m_ref [3] = '{0, 0, 0};
    int m_flag [3] = '{0, 0, 0};

    always #(CLK_T/2) clk = ~clk;

    sector_ref_select u_sector_ref_select (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .va(va), .vb(vb), .vc(vc), .half_bus(half_bus),
        .out_valid(out_valid), .region(region),
        .ref_p(ref_p), .ref_n(ref_n), .ref_x(ref_x),
        .flag_p(flag_p), .flag_n(flag_n), .flag_x(flag_x)
    );

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int f_region(int a, int b, int c, int prev);
        if (a > 0 && b <= 0 && c > 0)  return 1;
        if (a > 0 && b <= 0 && c <= 0) return 2;
        if (a > 0 && b > 0 && c <= 0)  return 3;
        if (a <= 0 && b > 0 && c <= 0) return 4;
        if (a <= 0 && b > 0 && c > 0)  return 5;
        if (a <= 0 && b <= 0 && c > 0) return 6;
        return prev;
    endfunction

    function automatic int f_sel(int r, int which, int a, int b, int c);
        int t [3];
        case (r)
            1: t = '{a - b, c - b, -b};
            2: t = '{a - b, a - c, a};
            3: t = '{b - c, a - c, -c};
            4: t = '{b - c, b - a, b};
            5: t = '{c - a, b - a, -a};
            default: t = '{c - a, c - b, c};
        endcase
        return t[which];
    endfunction

    task automatic compare(string tag);
        int act [3];
        int actf [3];
        act  = '{int'(ref_p), int'(ref_n), int'(ref_x)};
        actf = '{int'(flag_p), int'(flag_n), int'(flag_x)};
        chk(int'(out_valid) == m_valid, {tag, " R2 out_valid"}, int'(out_valid), m_valid);
        chk(int'(region) == m_region, {tag, " R3 region"}, int'(region), m_region);
        chk(region >= 1 && region <= 6, {tag, " R9 region range"}, int'(region), m_region);
        for (int i = 0; i < 3; i++) begin
            chk(act[i] == m_ref[i], $sformatf("%s R5 %s ref%0d", tag,
                m_flag[i] != 0 ? "R6" : "R7", i), act[i], m_ref[i]);
            chk(actf[i] == m_flag[i], $sformatf("%s R5 %s flag%0d", tag,
                m_flag[i] != 0 ? "R6" : "R7", i), actf[i], m_flag[i]);
        end
    endtask

    // called at a falling edge; returns at the next falling edge after checking
    task automatic step(bit v, int a, int b, int c, int e, string tag);
        in_valid = v;
        va = DATA_W'(a); vb = DATA_W'(b); vc = DATA_W'(c); half_bus = DATA_W'(e);
        @(posedge clk);
        m_valid = v;
        if (v) begin
            m_region = f_region(a, b, c, m_region);
            for (int i = 0; i < 3; i++) begin
                int s;
                s = f_sel(m_region, i, a, b, c);
                m_flag[i] = (s >= e) ? 1 : 0;
                m_ref[i]  = (s >= e) ? s - e : s;
            end
        end
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        #(CLK_T * 200000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        compare("R1 in-reset");
        rst = 1'b0;
        @(negedge clk);
        compare("R1 after-reset");

        // every sign pattern, one region each
        step(1,  8000, -4000,  2000, 30000, "R3 pattern101");
        step(1, 10000, -3000, -3000, 30000, "R3 pattern100");
        step(1,  5000,  6000, -7000, 30000, "R3 pattern110");
        step(1, -2000,  9000, -1000, 30000, "R3 pattern010");
        step(1, -9000,  4000,  3000, 30000, "R3 pattern011");
        step(1, -1000, -1000,  5000, 30000, "R3 pattern001");
        step(1,     5,     0,     0, 30000, "R3 zero-is-negative");

        // held region on uniform patterns
        step(1,     0,     0,     0,  1000, "R4 all-zero");
        step(1,   100,   200,   300,    50, "R4 all-positive");
        step(1,  -100,  -200,  -300,  -150, "R4 all-negative");

        // quiet cycles hold outputs
        step(0,  7000, -7000,  7000,     0, "R8 idle");
        step(0, -7000,  7000, -7000,     0, "R8 idle2");

        // region change and exact boundary in the same strobe
        step(1, 10000, -3000, -3000, 12000, "R10 pre");
        step(1,  8000, -4000,  2000, 12000, "R10 change-and-equal-p");
        step(1, 10000, -3000, -3000,  4000, "R10 pre2");
        step(1,  8000, -4000,  2000,  4000, "R10 change-and-equal-x");

        // full-scale extremes
        step(1, -32768, 32767, 32767, -32768, "R6 extreme-max");
        step(1, 32767, -32768, -32768, 32767, "R7 extreme-mixed");
        step(1, 32767, -32768, 32767, -32768, "R6 extreme-r1");

        // three-phase sine sweep covering all regions in order
        for (int k = 0; k < 300; k++) begin
            real t;
            int a, b, c, e;
            t = 6.283185307 * k / 100.0;
            a = $rtoi(20000.0 * $sin(t));
            b = $rtoi(20000.0 * $sin(t - 2.094395102));
            c = $rtoi(20000.0 * $sin(t + 2.094395102));
            e = (k % 3 == 0) ? 10000 : 15000;
            step(1, a, b, c, e, "R5 sweep");
        end

        // random strobes and values
        for (int k = 0; k < 400; k++) begin
            int a, b, c, e;
            bit v;
            v = ($urandom % 4) != 0;
            a = int'($urandom % 65536) - 32768;
            b = int'($urandom % 65536) - 32768;
            c = int'($urandom % 65536) - 32768;
            e = int'($urandom % 40000) - 7232;
            step(v, a, b, c, e, "R8 random");
        end

        rst = 1'b1;
        m_valid = 0; m_region = 1;
        m_ref = '{0, 0, 0}; m_flag = '{0, 0, 0};
        @(negedge clk);
        compare("R1 re-reset");

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule